// File: doc/BRIEF.md
# Averaged Read Strobe Eye Trainer

This block finds a read strobe delay for each of eight byte lanes. A lane delay has two fields: a coarse tap and a fine phase. The phase runs through its range, and each wrap moves the tap up by one, so a delay is really one step count. For each populated rank, the trainer first clears every lane to step zero. It then moves up every lane whose read still fails, until that lane reads correctly. This gives the lower edge of the eye. From that point it keeps moving up every lane whose read still succeeds, until the read fails again. This gives the upper edge. The pattern readback is not part of the block. Each trial is a request/acknowledge exchange: the trainer presents the current lane delays and the rank under test, and the environment answers with one error bit per lane.

When more than one rank is populated, the eye of each lane is narrowed to the region common to all ranks. The centre of that region is added to a per-lane sum. The whole sweep over all ranks runs a fixed number of times (three by default), and the sum is then divided by that count. The averaged step count is split back into tap and phase. It is then written into two 16-bit configuration words per lane, one holding a tap sub-field for each rank and one holding a phase sub-field for each rank. The same value goes into the sub-field of every populated rank.

Top module: `strobe_eye_trainer`

## Requirements
- R1: After reset `busy`, `test_req`, `done`, `fail` and every bit of `cfg_tap` and `cfg_ph` are 0.
- R2: The first trial of every rank search in every sweep presents tap 0 and phase 0 on all lanes.
- R3: A lane delay moves by at most one step between trials. A step counts phase 0 to 7, then wraps phase to 0 and adds one to the tap (tap 0 to 14). The step count is tap*8+phase. While `test_req` is high the presented delays do not change.
- R4: In the pass search, a lane with error bit 1 (`err_mask[l]`=1 means lane l failed) moves up one step. A lane with error bit 0 stops, and its step count is its lower limit.
- R5: The fail search starts from the delays the pass search reached, with no reset. A lane with error bit 0 moves up one step. A lane with error bit 1 stops, and its step count is its upper limit.
- R6: If a lane at tap 14 phase 7 still fails during the pass search, training ends with `done` and `fail`=1, and both configuration buses keep their previous values.
- R7: If a lane at tap 14 phase 7 still passes during the fail search, that lane stops with upper limit 119, and the other lanes continue normally.
- R8: With several populated ranks, a lane uses the largest of the rank lower limits and the smallest of the rank upper limits. The sweep centre is floor((lower+upper)/2).
- R9: The sweep over all populated ranks runs 3 times. The final step count of a lane is floor(sum of the 3 centres / 3), split into tap = count/8 and phase = count mod 8.
- R10: Lane l's tap word is `cfg_tap[16*l +: 16]`, with rank r's tap in bits [4r+3:4r]. Its phase word is `cfg_ph[16*l +: 16]`, with rank r's phase in bits [3r+2:3r]. Only populated ranks' fields are written. All other bits keep their value.
- R11: With no rank populated, `start` leads to `done` with `fail`=1 and no trial is requested.
- R12: `test_ack` has no effect unless `test_req` is high. `start` has no effect while `busy` is high. `done` is high for exactly one cycle per run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a training run (ignored while busy) |
| rank_pop | input | 4 | Populated-rank mask, bit r for rank r |
| busy | output | 1 | A run is in progress |
| test_req | output | 1 | A trial is requested with the presented delays |
| test_rank | output | 2 | Rank the current trial addresses |
| dly_tap | output | 32 | Tap under test, 4 bits per lane |
| dly_ph | output | 24 | Phase under test, 3 bits per lane |
| test_ack | input | 1 | Trial result valid on `err_mask` |
| err_mask | input | 8 | Per-lane trial error bits, 1 = lane read wrong |
| done | output | 1 | One-cycle pulse at the end of a run |
| fail | output | 1 | Run ended without a result; held until next start |
| cfg_tap | output | 128 | Per-lane tap configuration words |
| cfg_ph | output | 128 | Per-lane phase configuration words |

## Verification
In the fail search, one lane can hit the end of the delay range in the same trial where another lane sees its first failing read. Both lanes then stop in one update, one on overflow and one on a match. The bench sets up this case by giving two lanes the same lower edge, with one upper edge just below the range end and the other beyond it. The two lanes then step in lockstep and resolve on the same response. The check is that both lanes finish with upper limit 119 and with the averaged centre the requirements predict, and that the run does not fail. The second such case is a pass-search overflow on one lane while other lanes are still stepping. There the run must abort with `fail` set and with the configuration words from the previous run unchanged.

// File: rtl/set_pkg.sv
package set_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RSEL,
      ST_CLEAR,
      ST_WAIT,
      ST_CHK,
      ST_MERGE,
      ST_PACK,
      ST_DONE
   } trn_state_t;
endpackage

// File: rtl/set_lane_step.sv
// One lane's delay stepper: tap/phase pair plus linear step count.
module set_lane_step #(
   parameter int TAP_W    = 4,
   parameter int PH_W     = 3,
   parameter int TAP_LAST = 14,
   parameter int PH_LAST  = 7,
   parameter int STEP_W   = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              arm,
   input  logic              upd,
   input  logic              hit,
   output logic [TAP_W-1:0]  tap_o,
   output logic [PH_W-1:0]   ph_o,
   output logic [STEP_W-1:0] steps_o,
   output logic              active_o,
   output logic              ovf_o
);
   localparam logic [TAP_W-1:0] TAP_END = TAP_W'(TAP_LAST);
   localparam logic [PH_W-1:0]  PH_END  = PH_W'(PH_LAST);

   logic [TAP_W-1:0]  tap_q;
   logic [PH_W-1:0]   ph_q;
   logic [STEP_W-1:0] steps_q;
   logic              act_q;
   logic              at_end;

   assign at_end   = (tap_q == TAP_END) && (ph_q == PH_END);
   assign ovf_o    = upd & act_q & ~hit & at_end;
   assign tap_o    = tap_q;
   assign ph_o     = ph_q;
   assign steps_o  = steps_q;
   assign active_o = act_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tap_q   <= '0;
         ph_q    <= '0;
         steps_q <= '0;
         act_q   <= 1'b0;
      end else if (clr) begin
         tap_q   <= '0;
         ph_q    <= '0;
         steps_q <= '0;
         act_q   <= 1'b1;
      end else if (arm) begin
         act_q <= 1'b1;
      end else if (upd && act_q) begin
         if (hit || at_end) begin
            act_q <= 1'b0;
         end else begin
            if (ph_q == PH_END) begin
               ph_q  <= '0;
               tap_q <= tap_q + 1'b1;
            end else begin
               ph_q <= ph_q + 1'b1;
            end
            steps_q <= steps_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/set_eye_acc.sv
// Per-lane eye intersection across ranks and centre accumulation over sweeps.
module set_eye_acc #(
   parameter int STEP_W = 7,
   parameter int ACC_W  = 9,
   parameter int SWEEPS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              first,
   input  logic              take_lo,
   input  logic              take_hi,
   input  logic [STEP_W-1:0] steps,
   input  logic              acc_clr,
   input  logic              add,
   output logic [STEP_W-1:0] avg_o
);
   logic [STEP_W-1:0] lo_q, hi_q;
   logic [ACC_W-1:0]  acc_q;
   logic [STEP_W:0]   pair_sum;
   logic [STEP_W:0]   centre;

   assign pair_sum = {1'b0, lo_q} + {1'b0, hi_q};
   assign centre   = pair_sum >> 1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q  <= '0;
         hi_q  <= '0;
         acc_q <= '0;
      end else begin
         if (take_lo)
            lo_q <= (first || steps > lo_q) ? steps : lo_q;
         if (take_hi)
            hi_q <= (first || steps < hi_q) ? steps : hi_q;
         if (acc_clr)
            acc_q <= '0;
         else if (add)
            acc_q <= acc_q + ACC_W'(centre);
      end
   end

   generate
      if (SWEEPS == 1) begin : g_single
         assign avg_o = STEP_W'(acc_q);
      end else begin : g_divide
         assign avg_o = STEP_W'(acc_q / ACC_W'(SWEEPS));
      end
   endgenerate
endmodule

// File: rtl/set_cfg_pack.sv
// Splits the averaged step count and writes per-rank sub-fields of one lane.
module set_cfg_pack #(
   parameter int NRANK   = 4,
   parameter int TAP_W   = 4,
   parameter int PH_W    = 3,
   parameter int PH_LAST = 7,
   parameter int STEP_W  = 7,
   parameter int CFG_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [NRANK-1:0]  rank_pop,
   input  logic [STEP_W-1:0] avg,
   output logic [CFG_W-1:0]  tap_word,
   output logic [CFG_W-1:0]  ph_word
);
   localparam logic [STEP_W-1:0] PH_CNT = STEP_W'(PH_LAST + 1);

   logic [TAP_W-1:0] tap_v;
   logic [PH_W-1:0]  ph_v;

   assign tap_v = TAP_W'(avg / PH_CNT);
   assign ph_v  = PH_W'(avg % PH_CNT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tap_word <= '0;
         ph_word  <= '0;
      end else if (wr) begin
         for (int r = 0; r < NRANK; r++) begin
            if (rank_pop[r]) begin
               tap_word[r*TAP_W +: TAP_W] <= tap_v;
               ph_word[r*PH_W +: PH_W]    <= ph_v;
            end
         end
      end
   end
endmodule

// File: rtl/strobe_eye_trainer.sv
module strobe_eye_trainer #(
   parameter int LANES    = 8,
   parameter int NRANK    = 4,
   parameter int TAP_W    = 4,
   parameter int PH_W     = 3,
   parameter int TAP_LAST = 14,
   parameter int PH_LAST  = 7,
   parameter int SWEEPS   = 3,
   parameter int CFG_W    = 16,
   localparam int RANK_W  = (NRANK > 1) ? $clog2(NRANK) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [NRANK-1:0]       rank_pop,
   output logic                   busy,
   output logic                   test_req,
   output logic [RANK_W-1:0]      test_rank,
   output logic [LANES*TAP_W-1:0] dly_tap,
   output logic [LANES*PH_W-1:0]  dly_ph,
   input  logic                   test_ack,
   input  logic [LANES-1:0]       err_mask,
   output logic                   done,
   output logic                   fail,
   output logic [LANES*CFG_W-1:0] cfg_tap,
   output logic [LANES*CFG_W-1:0] cfg_ph
);
   import set_pkg::*;

   localparam int STEPS  = (TAP_LAST + 1) * (PH_LAST + 1);
   localparam int STEP_W = $clog2(STEPS);
   localparam int ACC_W  = $clog2(SWEEPS * STEPS);
   localparam int RCNT_W = $clog2(NRANK + 1);
   localparam int SW_W   = $clog2(SWEEPS) + 1;

   generate
      if (NRANK * TAP_W > CFG_W) begin : g_bad_tap
         $error("tap sub-fields do not fit the configuration word");
      end
      if (NRANK * PH_W > CFG_W) begin : g_bad_ph
         $error("phase sub-fields do not fit the configuration word");
      end
      if (TAP_LAST >= (1 << TAP_W) || PH_LAST >= (1 << PH_W)) begin : g_bad_range
         $error("delay range exceeds field width");
      end
      if (SWEEPS < 1) begin : g_bad_sweeps
         $error("at least one sweep is required");
      end
   endgenerate

   trn_state_t         state_q;
   logic [RCNT_W-1:0]  rank_q;
   logic [SW_W-1:0]    sweep_q;
   logic               fmode_q, first_q, fatal_q, fail_q;

   logic [LANES-1:0]   act, ovf, hit;
   logic [STEP_W-1:0]  steps [LANES];
   logic [STEP_W-1:0]  avg   [LANES];
   logic               any_act, clr, arm, upd, take_hi, add, wr, acc_clr;

   assign any_act = |act;
   assign clr     = (state_q == ST_CLEAR);
   assign upd     = (state_q == ST_WAIT) && test_ack;
   assign arm     = (state_q == ST_CHK) && !fatal_q && !any_act && !fmode_q;
   assign take_hi = (state_q == ST_CHK) && !fatal_q && !any_act && fmode_q;
   assign add     = (state_q == ST_MERGE) && !first_q;
   assign wr      = (state_q == ST_PACK);
   assign acc_clr = (state_q == ST_IDLE) && start;
   assign hit     = fmode_q ? err_mask : ~err_mask;

   assign busy      = (state_q != ST_IDLE);
   assign test_req  = (state_q == ST_WAIT);
   assign done      = (state_q == ST_DONE);
   assign fail      = fail_q;
   assign test_rank = rank_q[RANK_W-1:0];

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         set_lane_step #(
            .TAP_W(TAP_W), .PH_W(PH_W), .TAP_LAST(TAP_LAST),
            .PH_LAST(PH_LAST), .STEP_W(STEP_W)
         ) i_step (
            .clk(clk), .rst_n(rst_n), .clr(clr), .arm(arm), .upd(upd),
            .hit(hit[l]),
            .tap_o(dly_tap[l*TAP_W +: TAP_W]),
            .ph_o(dly_ph[l*PH_W +: PH_W]),
            .steps_o(steps[l]), .active_o(act[l]), .ovf_o(ovf[l])
         );

         set_eye_acc #(
            .STEP_W(STEP_W), .ACC_W(ACC_W), .SWEEPS(SWEEPS)
         ) i_acc (
            .clk(clk), .rst_n(rst_n), .first(first_q), .take_lo(arm),
            .take_hi(take_hi), .steps(steps[l]), .acc_clr(acc_clr),
            .add(add), .avg_o(avg[l])
         );

         set_cfg_pack #(
            .NRANK(NRANK), .TAP_W(TAP_W), .PH_W(PH_W), .PH_LAST(PH_LAST),
            .STEP_W(STEP_W), .CFG_W(CFG_W)
         ) i_pack (
            .clk(clk), .rst_n(rst_n), .wr(wr), .rank_pop(rank_pop),
            .avg(avg[l]),
            .tap_word(cfg_tap[l*CFG_W +: CFG_W]),
            .ph_word(cfg_ph[l*CFG_W +: CFG_W])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         rank_q  <= '0;
         sweep_q <= '0;
         fmode_q <= 1'b0;
         first_q <= 1'b1;
         fatal_q <= 1'b0;
         fail_q  <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: if (start) begin
               rank_q  <= '0;
               sweep_q <= '0;
               first_q <= 1'b1;
               fatal_q <= 1'b0;
               fail_q  <= 1'b0;
               state_q <= ST_RSEL;
            end
            ST_RSEL: begin
               if (rank_q == RCNT_W'(NRANK))
                  state_q <= ST_MERGE;
               else if (rank_pop[rank_q[RANK_W-1:0]])
                  state_q <= ST_CLEAR;
               else
                  rank_q <= rank_q + 1'b1;
            end
            ST_CLEAR: begin
               fmode_q <= 1'b0;
               state_q <= ST_WAIT;
            end
            ST_WAIT: if (test_ack) begin
               if (!fmode_q && (|ovf))
                  fatal_q <= 1'b1;
               state_q <= ST_CHK;
            end
            ST_CHK: begin
               if (fatal_q) begin
                  fail_q  <= 1'b1;
                  state_q <= ST_DONE;
               end else if (any_act) begin
                  state_q <= ST_WAIT;
               end else if (!fmode_q) begin
                  fmode_q <= 1'b1;
                  state_q <= ST_WAIT;
               end else begin
                  first_q <= 1'b0;
                  rank_q  <= rank_q + 1'b1;
                  state_q <= ST_RSEL;
               end
            end
            ST_MERGE: begin
               if (first_q) begin
                  fail_q  <= 1'b1;
                  state_q <= ST_DONE;
               end else if (sweep_q == SW_W'(SWEEPS - 1)) begin
                  state_q <= ST_PACK;
               end else begin
                  sweep_q <= sweep_q + 1'b1;
                  rank_q  <= '0;
                  first_q <= 1'b1;
                  state_q <= ST_RSEL;
               end
            end
            ST_PACK: state_q <= ST_DONE;
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/strobe_eye_trainer_chk.sv
module strobe_eye_trainer_chk #(
   parameter int LANES    = 8,
   parameter int NRANK    = 4,
   parameter int TAP_W    = 4,
   parameter int PH_W     = 3,
   parameter int TAP_LAST = 14,
   parameter int PH_LAST  = 7,
   parameter int CFG_W    = 16
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   busy,
   input logic                   test_req,
   input logic                   done,
   input logic                   fail,
   input logic [LANES*TAP_W-1:0] dly_tap,
   input logic [LANES*PH_W-1:0]  dly_ph,
   input logic [LANES*CFG_W-1:0] cfg_tap,
   input logic [LANES*CFG_W-1:0] cfg_ph
);
   // R12
   idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !test_req);

   // R12
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R3
   hold_dly_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (test_req && $past(test_req)) |-> ($stable(dly_tap) && $stable(dly_ph)));

   // R6
   fatal_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fail) |-> ($stable(cfg_tap) && $stable(cfg_ph)));

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         // R3
         dly_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (dly_tap[l*TAP_W +: TAP_W] <= TAP_W'(TAP_LAST)) &&
            (dly_ph[l*PH_W +: PH_W] <= PH_W'(PH_LAST)));
         for (genvar r = 0; r < NRANK; r++) begin : g_rank
            // R10
            cfg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (cfg_tap[l*CFG_W + r*TAP_W +: TAP_W] <= TAP_W'(TAP_LAST)) &&
               (cfg_ph[l*CFG_W + r*PH_W +: PH_W] <= PH_W'(PH_LAST)));
         end
      end
   endgenerate
endmodule

bind strobe_eye_trainer strobe_eye_trainer_chk #(
   .LANES(LANES), .NRANK(NRANK), .TAP_W(TAP_W), .PH_W(PH_W),
   .TAP_LAST(TAP_LAST), .PH_LAST(PH_LAST), .CFG_W(CFG_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .test_req(test_req),
   .done(done), .fail(fail), .dly_tap(dly_tap), .dly_ph(dly_ph),
   .cfg_tap(cfg_tap), .cfg_ph(cfg_ph)
);

// File: tb/test_strobe_eye_trainer.sv
module test_strobe_eye_trainer;
   localparam int LANES = 8;
   localparam int NRANK = 4;
   localparam int LAST  = 119;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               start = 1'b0;
   logic [NRANK-1:0]   rank_pop = '0;
   logic               busy, test_req, done, fail;
   logic [1:0]         test_rank;
   logic [LANES*4-1:0] dly_tap;
   logic [LANES*3-1:0] dly_ph;
   logic               resp_ack = 1'b0, poke_ack = 1'b0;
   logic [LANES-1:0]   resp_err = '0;
   logic [LANES*16-1:0] cfg_tap, cfg_ph;

   strobe_eye_trainer i_strobe_eye_trainer (
      .clk(clk), .rst_n(rst_n), .start(start), .rank_pop(rank_pop),
      .busy(busy), .test_req(test_req), .test_rank(test_rank),
      .dly_tap(dly_tap), .dly_ph(dly_ph), .test_ack(resp_ack | poke_ack),
      .err_mask(resp_err), .done(done), .fail(fail),
      .cfg_tap(cfg_tap), .cfg_ph(cfg_ph)
   );

   always #5 clk = ~clk;

   int n_chk = 0, n_bad = 0;
   int win_lo [NRANK][LANES];
   int win_hi [NRANK][LANES];
   int jit [3];
   int npop, search_cnt, req_cnt, viol, done_cnt;
   bit prev_nz, first_zero;
   int prev_step [LANES];

   task automatic chk(string req, int got, int exp, string what);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
      end
   endtask

   // environment: lane l reads correctly when its step count is inside its window
   initial begin
      forever begin
         @(negedge clk);
         if (resp_ack) begin
            resp_ack = 1'b0;
         end else if (test_req) begin
            bit allz;
            int sw, s;
            allz = (dly_tap == '0) && (dly_ph == '0);
            if (req_cnt == 0) first_zero = allz;
            if (allz && prev_nz) search_cnt++;
            else begin
               for (int l = 0; l < LANES; l++) begin
                  s = dly_tap[l*4 +: 4] * 8 + dly_ph[l*3 +: 3];
                  if (s < prev_step[l] || s > prev_step[l] + 1) viol++;
               end
            end
            prev_nz = !allz;
            req_cnt++;
            sw = (npop > 0) ? (search_cnt - 1) / npop : 0;
            if (sw > 2) sw = 2;
            for (int l = 0; l < LANES; l++) begin
               s = dly_tap[l*4 +: 4] * 8 + dly_ph[l*3 +: 3];
               prev_step[l] = s;
               resp_err[l] = !(s >= win_lo[test_rank][l] + jit[sw] &&
                               s <= win_hi[test_rank][l] + jit[sw]);
            end
            resp_ack = 1'b1;
         end
      end
   end

   always @(negedge clk) if (done) done_cnt++;

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   function automatic int exp_avg(int l, logic [NRANK-1:0] pop);
      int sum = 0;
      for (int j = 0; j < 3; j++) begin
         int lo_m = -1, hi_m = 1000;
         for (int r = 0; r < NRANK; r++) begin
            if (pop[r]) begin
               int lo = win_lo[r][l] + jit[j];
               int hi = win_hi[r][l] + jit[j];
               int up = (hi >= LAST) ? LAST : hi + 1;
               if (lo > lo_m) lo_m = lo;
               if (up < hi_m) hi_m = up;
            end
         end
         sum += (lo_m + hi_m) / 2;
      end
      return sum / 3;
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic run(logic [NRANK-1:0] pop, bit extra);
      int n = 0;
      rank_pop = pop; npop = $countones(pop);
      search_cnt = 0; req_cnt = 0; prev_nz = 1; viol = 0; done_cnt = 0;
      start = 1'b1; @(negedge clk); start = 1'b0;
      if (extra) begin
         repeat (20) @(negedge clk);
         start = 1'b1; @(negedge clk); start = 1'b0;
      end
      while (!done && n < 100000) begin @(negedge clk); n++; end
      repeat (3) @(negedge clk);
   endtask

   task automatic check_cfg(string req, logic [NRANK-1:0] pop);
      for (int l = 0; l < LANES; l++) begin
         int a = exp_avg(l, pop);
         for (int r = 0; r < NRANK; r++) begin
            chk(req, cfg_tap[l*16 + r*4 +: 4], pop[r] ? a / 8 : 0, $sformatf("tap lane%0d rank%0d", l, r));
            chk(req, cfg_ph[l*16 + r*3 +: 3], pop[r] ? a % 8 : 0, $sformatf("phase lane%0d rank%0d", l, r));
         end
      end
   endtask

   task automatic set_windows(int base);
      for (int r = 0; r < NRANK; r++)
         for (int l = 0; l < LANES; l++) begin
            win_lo[r][l] = base + 3 * l + 2 * r;
            win_hi[r][l] = base + 40 + 5 * l - 3 * r;
         end
      jit[0] = 0; jit[1] = 0; jit[2] = 0;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1", busy, 0, "busy");
      chk("R1", test_req, 0, "test_req");
      chk("R1", done, 0, "done");
      chk("R1", fail, 0, "fail");
      chk("R1", int'(cfg_tap == '0 && cfg_ph == '0), 1, "cfg zero");
   endtask

   task automatic t_single();
      do_reset(); set_windows(10);
      run(4'b0001, 0);
      chk("R2", int'(first_zero), 1, "first trial at zero");
      chk("R3", viol, 0, "step continuity");
      chk("R9", fail, 0, "fail flag");
      chk("R4", done_cnt, 1, "done pulses");
      // R5: a reset before the fail search would give wrong upper limits
      check_cfg("R5", 4'b0001);
   endtask

   task automatic t_two_rank();
      do_reset(); set_windows(5);
      run(4'b0101, 0);
      chk("R8", fail, 0, "fail flag");
      chk("R3", viol, 0, "step continuity");
      check_cfg("R8", 4'b0101);
      check_cfg("R10", 4'b0101);
   endtask

   task automatic t_average();
      do_reset(); set_windows(8);
      jit[0] = 0; jit[1] = 1; jit[2] = 3;
      run(4'b0010, 0);
      chk("R9", fail, 0, "fail flag");
      chk("R2", search_cnt, 3, "sweeps seen");
      check_cfg("R9", 4'b0010);
   endtask

   task automatic t_fail_ovf();
      do_reset(); set_windows(10);
      win_lo[0][0] = 90; win_hi[0][0] = 130;
      win_lo[0][1] = 90; win_hi[0][1] = 118;
      run(4'b0001, 0);
      chk("R7", fail, 0, "fail flag");
      check_cfg("R7", 4'b0001);
   endtask

   task automatic t_fatal();
      logic [LANES*16-1:0] old_tap, old_ph;
      do_reset(); set_windows(12);
      run(4'b0001, 0);
      old_tap = cfg_tap; old_ph = cfg_ph;
      win_lo[0][3] = 200; win_hi[0][3] = 250;
      run(4'b0001, 0);
      chk("R6", fail, 1, "fail flag");
      chk("R6", done_cnt, 1, "done pulses");
      chk("R6", int'(cfg_tap == old_tap && cfg_ph == old_ph), 1, "cfg kept");
      chk("R6", busy, 0, "busy after abort");
   endtask

   task automatic t_none();
      do_reset(); set_windows(10);
      run(4'b0000, 0);
      chk("R11", fail, 1, "fail flag");
      chk("R11", req_cnt, 0, "trial requests");
      chk("R11", done_cnt, 1, "done pulses");
   endtask

   task automatic t_ignore();
      do_reset(); set_windows(6);
      poke_ack = 1'b1; @(negedge clk); poke_ack = 1'b0;
      repeat (3) @(negedge clk);
      chk("R12", busy, 0, "busy after stray ack");
      chk("R12", int'(cfg_tap == '0 && cfg_ph == '0), 1, "cfg after stray ack");
      run(4'b1000, 1);
      chk("R12", done_cnt, 1, "done pulses with extra start");
      chk("R12", busy, 0, "busy after run");
      check_cfg("R12", 4'b1000);
   endtask

   initial begin
      t_reset();
      t_single();
      t_two_rank();
      t_average();
      t_fail_ovf();
      t_fatal();
      t_none();
      t_ignore();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule